// File: doc/BRIEF.md
# Two-Bank Pin Controller with Edge Events

This block is a register-mapped general-purpose pin controller. Its pins are split into two groups: a main bank and a second bank kept at a separate address window. Each bank holds eight byte-addressable registers for every pin:

- a pin enable;
- a direction;
- an output level;
- separate rising and falling trigger enables;
- an event mask;
- a spare routing register;
- a sticky trigger status.

Incoming pad values pass through a two-flop synchronizer. A pin that is enabled and armed for an edge latches a pending status bit when that edge is seen. Software clears a pending bit by writing a one to it.

Every pending status bit whose event mask is open feeds one level-sensitive event line, shared by both banks. The line stays high until software clears all of those bits. Register access uses a simple byte-wide bus: one write strobe, and a read data path that always reflects the addressed byte.

Top module: `gpio_banked`

## Requirements
- R1: After reset every register is zero except the direction bits, which reset to one (input). So `pad_oe` is all zero, `evt_out` is low and every status byte reads zero.
- R2: Address bit 5 selects the bank (0 main, 1 second). Address bits 4:2 select the register: 0 enable, 1 direction, 2 level, 3 rising enable, 4 falling enable, 5 event mask, 6 spare, 7 status. Address bits 1:0 select the byte. Pin n of a bank sits at byte n/8, bit n%8. Bits above the bank's pin count read as zero and ignore writes.
- R3: `pad_oe` for a pin is high exactly when its enable bit is 1 and its direction bit is 0 (output). `pad_out` carries the pin's level register bit.
- R4: A read of the level register returns, for each pin:
  - 0 when the pin is disabled;
  - the level register bit when the pin is an output;
  - the synchronized pad value when the pin is an input.
- R5: With only the rising enable set, a 0-to-1 pad change sets the status bit on the third rising clock edge after the change. A 1-to-0 change sets nothing.
- R6: With only the falling enable set, a 1-to-0 pad change sets the status bit, and a 0-to-1 change sets nothing.
- R7: With both trigger enables set, either pad transition sets the status bit.
- R8: A pin whose enable bit is 0, or whose trigger enables are both 0, never sets its status bit.
- R9: Writing 1 to a status bit clears it on the next clock edge. Writing 0 leaves it unchanged.
- R10: When a clearing write and a new enabled edge hit the same status bit in the same cycle, the bit stays set.
- R11: `evt_out` is high while any status bit whose event mask bit is 1 is set, in either bank. A set status bit whose mask is 0 does not raise it.
- R12: The spare routing register reads back what was written, and it affects neither `evt_out` nor the pads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address (bit 5 bank, bits 4:2 register, bits 1:0 byte) |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed byte, combinational |
| pad_in | input | CORE_PINS+RES_PINS | Pad input values; main bank in the low bits |
| pad_out | output | CORE_PINS+RES_PINS | Driven pad levels |
| pad_oe | output | CORE_PINS+RES_PINS | Pad output enables |
| evt_out | output | 1 | Level-sensitive combined event |

## Verification
A status bit can be cleared by a software write and set by a new edge in the same cycle. The bench provokes this on a pin armed for both edges that is already pending. It drops the pad and times the clearing write so that it lands on the third clock edge, the same edge on which the synchronized falling edge is latched. The status byte must still read one afterwards. A separate clearing write with no edge present must then bring it to zero, which shows that the retained bit came from the collision and not from a failed clear.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Register slot inside a bank; the numeric order fixes the address map.
    typedef enum logic [2:0] {
        SLOT_ENABLE = 3'd0,
        SLOT_DIR    = 3'd1,
        SLOT_LEVEL  = 3'd2,
        SLOT_RISE   = 3'd3,
        SLOT_FALL   = 3'd4,
        SLOT_MASK   = 3'd5,
        SLOT_SPARE  = 3'd6,
        SLOT_STATUS = 3'd7
    } slot_e;

    typedef struct packed {
        logic       wr;
        logic       bank;
        slot_e      slot;
        logic [1:0] byte_idx;
        logic [7:0] data;
    } bus_req_t;

    localparam int MAX_BANK_PINS = 32;

    function automatic bus_req_t decode_req(input logic [5:0] addr,
                                            input logic       wr,
                                            input logic [7:0] wdata);
        bus_req_t r;
        r.wr       = wr;
        r.bank     = addr[5];
        r.slot     = slot_e'(addr[4:2]);
        r.byte_idx = addr[1:0];
        r.data     = wdata;
        return r;
    endfunction

    function automatic logic [7:0] pick_byte(input logic [31:0] vec,
                                             input logic [1:0]  idx);
        return vec[{idx, 3'b000} +: 8];
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  logic             bank_hit,
    input  logic [NPINS-1:0] pin_sync,
    output logic [7:0]       rd_byte,
    output logic [NPINS-1:0] oe,
    output logic [NPINS-1:0] lvl_out,
    output logic             pend
);
    localparam int PADW = MAX_BANK_PINS;

    logic [NPINS-1:0] en_q, dir_q, lvl_q, rise_q, fall_q, mask_q, spare_q, sts_q;
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] hit, clr, level_view;
    logic             wr_here;

    assign wr_here = req.wr && bank_hit;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= pin_sync;
    end

    genvar i;
    generate
        for (i = 0; i < NPINS; i++) begin : g_pin
            localparam logic [1:0] BY = 2'(i / 8);
            localparam int         BI = i % 8;
            logic wsel;

            assign wsel   = wr_here && (req.byte_idx == BY);
            assign hit[i] = en_q[i] &&
                            ((rise_q[i] &&  pin_sync[i] && !prev_q[i]) ||
                             (fall_q[i] && !pin_sync[i] &&  prev_q[i]));
            assign clr[i] = wsel && (req.slot == SLOT_STATUS) && req.data[BI];
            assign level_view[i] = en_q[i] && (dir_q[i] ? pin_sync[i] : lvl_q[i]);

            always_ff @(posedge clk) begin
                if (rst) begin
                    en_q[i]    <= 1'b0;
                    dir_q[i]   <= 1'b1;
                    lvl_q[i]   <= 1'b0;
                    rise_q[i]  <= 1'b0;
                    fall_q[i]  <= 1'b0;
                    mask_q[i]  <= 1'b0;
                    spare_q[i] <= 1'b0;
                    sts_q[i]   <= 1'b0;
                end else begin
                    if (wsel) begin
                        case (req.slot)
                            SLOT_ENABLE: en_q[i]    <= req.data[BI];
                            SLOT_DIR:    dir_q[i]   <= req.data[BI];
                            SLOT_LEVEL:  lvl_q[i]   <= req.data[BI];
                            SLOT_RISE:   rise_q[i]  <= req.data[BI];
                            SLOT_FALL:   fall_q[i]  <= req.data[BI];
                            SLOT_MASK:   mask_q[i]  <= req.data[BI];
                            SLOT_SPARE:  spare_q[i] <= req.data[BI];
                            default: ;
                        endcase
                    end
                    // a fresh edge outranks a clearing write
                    sts_q[i] <= hit[i] || (sts_q[i] && !clr[i]);
                end
            end

            assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (rst)
                (clr[i] && !hit[i]) |=> !sts_q[i]);
            assert_edge_wins_R10: assert property (@(posedge clk) disable iff (rst)
                hit[i] |=> sts_q[i]);
            assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
                (sts_q[i] && !clr[i]) |=> sts_q[i]);
            assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
                $rose(sts_q[i]) |-> $past(en_q[i]));
        end
    endgenerate

    assign oe      = en_q & ~dir_q;
    assign lvl_out = lvl_q;
    assign pend    = |(sts_q & mask_q);

    always_comb begin
        logic [PADW-1:0] v;
        case (req.slot)
            SLOT_ENABLE: v = PADW'(en_q);
            SLOT_DIR:    v = PADW'(dir_q);
            SLOT_LEVEL:  v = PADW'(level_view);
            SLOT_RISE:   v = PADW'(rise_q);
            SLOT_FALL:   v = PADW'(fall_q);
            SLOT_MASK:   v = PADW'(mask_q);
            SLOT_SPARE:  v = PADW'(spare_q);
            default:     v = PADW'(sts_q);
        endcase
        rd_byte = pick_byte(v, req.byte_idx);
    end
endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
    import gpio_pkg::*;
#(
    parameter int CORE_PINS = 10,
    parameter int RES_PINS  = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [5:0]                    bus_addr,
    input  logic                          bus_wr,
    input  logic [7:0]                    bus_wdata,
    output logic [7:0]                    bus_rdata,
    input  logic [CORE_PINS+RES_PINS-1:0] pad_in,
    output logic [CORE_PINS+RES_PINS-1:0] pad_out,
    output logic [CORE_PINS+RES_PINS-1:0] pad_oe,
    output logic                          evt_out
);
    localparam int NPIN = CORE_PINS + RES_PINS;

    bus_req_t        req;
    logic [NPIN-1:0] pin_sync;
    logic [7:0]      core_rd, res_rd;
    logic            core_pend, res_pend;

    assign req = decode_req(bus_addr, bus_wr, bus_wdata);

    gpio_sync #(.WIDTH(NPIN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_sync)
    );

    gpio_bank #(.NPINS(CORE_PINS)) u_core (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .bank_hit (!req.bank),
        .pin_sync (pin_sync[CORE_PINS-1:0]),
        .rd_byte  (core_rd),
        .oe       (pad_oe[CORE_PINS-1:0]),
        .lvl_out  (pad_out[CORE_PINS-1:0]),
        .pend     (core_pend)
    );

    gpio_bank #(.NPINS(RES_PINS)) u_res (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .bank_hit (req.bank),
        .pin_sync (pin_sync[NPIN-1:CORE_PINS]),
        .rd_byte  (res_rd),
        .oe       (pad_oe[NPIN-1:CORE_PINS]),
        .lvl_out  (pad_out[NPIN-1:CORE_PINS]),
        .pend     (res_pend)
    );

    assign bus_rdata = req.bank ? res_rd : core_rd;
    assign evt_out   = core_pend | res_pend;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!evt_out && pad_oe == '0));
    assert_oe_needs_write_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(|pad_oe) |-> $past(bus_wr));
endmodule

// File: tb/gpio_banked_test.sv
`timescale 1ns/1ps
module gpio_banked_test;
    localparam int CP = 10;
    localparam int RP = 6;
    localparam int NP = CP + RP;

    typedef struct {
        int          kind;   // 0 read byte, 1 event line, 2 pad_oe, 3 pad_out
        logic [15:0] exp;
        string       tag;
    } item_t;

    logic          clk = 0;
    logic          rst = 1;
    logic [5:0]    bus_addr = '0;
    logic          bus_wr = 0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic          evt_out;

    int  checks = 0, fails = 0;
    bit  done = 0;
    item_t q[$];

    always #10 clk = ~clk;

    gpio_banked #(.CORE_PINS(CP), .RES_PINS(RP)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .evt_out(evt_out));

    // monitor: pops expectations and compares after the edge has settled
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = q.pop_front();
                case (it.kind)
                    0: act = 16'(bus_rdata);
                    1: act = 16'(evt_out);
                    2: act = 16'(pad_oe);
                    default: act = 16'(pad_out);
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic expect_item(input int kind, input logic [5:0] a,
                               input logic [15:0] e, input string tag);
        item_t it;
        @(negedge clk);
        if (kind == 0) bus_addr = a;
        it.kind = kind; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(posedge clk);
        #8;
    endtask

    task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
        expect_item(0, a, 16'(e), tag);
    endtask

    task automatic set_pad(input int idx, input logic v);
        @(negedge clk);
        pad_in[idx] = v;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1 reset state
        rd(6'h04, 8'hFF, "R1 main dir byte0");
        rd(6'h05, 8'h03, "R1 main dir byte1");
        rd(6'h24, 8'h3F, "R1 second dir");
        rd(6'h1C, 8'h00, "R1 status");
        expect_item(1, 0, 16'h0, "R1 evt low");
        expect_item(2, 0, 16'h0, "R1 oe low");

        // R3 drive: enable main pins, pins 0..3 outputs, level 0101
        wr(6'h00, 8'hFF); wr(6'h01, 8'h03);
        wr(6'h04, 8'hF0); wr(6'h08, 8'h05);
        expect_item(2, 0, 16'h000F, "R3 pad_oe");
        expect_item(3, 0, 16'h0005, "R3 pad_out");

        // R4 level read: outputs show driven value, inputs show pads
        rd(6'h08, 8'h05, "R4 level with quiet pads");
        set_pad(5, 1); set_pad(7, 1);
        rd(6'h08, 8'hA5, "R4 level mixed");
        set_pad(10, 1);
        rd(6'h28, 8'h00, "R4 disabled pin reads zero");

        // R2 second bank window and unused bits
        wr(6'h20, 8'hFF);
        rd(6'h20, 8'h3F, "R2 unused enable bits read zero");
        rd(6'h28, 8'h01, "R2 second bank level");

        // R5 rising only on main pin 4
        wr(6'h0C, 8'h10);
        set_pad(4, 1);
        rd(6'h1C, 8'h10, "R5 rise sets status");
        wr(6'h1C, 8'h10);
        rd(6'h1C, 8'h00, "R9 clear by one");
        set_pad(4, 0);
        rd(6'h1C, 8'h00, "R5 fall ignored");

        // R6 falling only on second bank pin 0, R11 masking, R9 write zero
        wr(6'h30, 8'h01);
        set_pad(10, 0);
        rd(6'h3C, 8'h01, "R6 fall sets status");
        expect_item(1, 0, 16'h0, "R11 masked status keeps evt low");
        wr(6'h34, 8'h01);
        expect_item(1, 0, 16'h1, "R11 unmasked status raises evt");
        wr(6'h3C, 8'h00);
        rd(6'h3C, 8'h01, "R9 write zero keeps status");
        set_pad(10, 1);
        rd(6'h3C, 8'h01, "R6 rise adds nothing");
        wr(6'h3C, 8'h01);
        rd(6'h3C, 8'h00, "R9 second bank clear");
        expect_item(1, 0, 16'h0, "R11 evt drops after clear");

        // R7 both edges on main pin 8 (byte 1)
        wr(6'h0D, 8'h01); wr(6'h11, 8'h01);
        set_pad(8, 1);
        rd(6'h1D, 8'h01, "R7 rise with both");
        wr(6'h1D, 8'h01);
        set_pad(8, 0);
        rd(6'h1D, 8'h01, "R7 fall with both");
        wr(6'h1D, 8'h01);
        rd(6'h1D, 8'h00, "R7 cleared");

        // R8 disabled pin 9 and unarmed pin 6
        wr(6'h01, 8'h01); wr(6'h0D, 8'h03);
        set_pad(9, 1);
        rd(6'h1D, 8'h00, "R8 disabled pin no status");
        set_pad(6, 1);
        rd(6'h1C, 8'h00, "R8 unarmed pin no status");

        // R10 clear and new edge in the same cycle on pin 8
        set_pad(8, 1);
        rd(6'h1D, 8'h01, "R10 pending before collision");
        @(negedge clk) pad_in[8] = 0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_addr = 6'h1D; bus_wdata = 8'h01; bus_wr = 1;
        @(negedge clk) bus_wr = 0;
        rd(6'h1D, 8'h01, "R10 edge wins over clear");
        wr(6'h1D, 8'h01);
        rd(6'h1D, 8'h00, "R10 plain clear afterwards");

        // R11 main bank contributes to the shared line
        wr(6'h15, 8'h01);
        set_pad(8, 1);
        expect_item(1, 0, 16'h1, "R11 main bank evt");
        wr(6'h1D, 8'h01);
        expect_item(1, 0, 16'h0, "R11 main bank evt cleared");

        // R12 spare register
        wr(6'h18, 8'hFF);
        rd(6'h18, 8'hFF, "R12 spare readback");
        expect_item(1, 0, 16'h0, "R12 spare leaves evt");
        expect_item(2, 0, 16'h000F, "R12 spare leaves pads");

        repeat (2) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule